// File: doc/BRIEF.md
# LZW Code Stream Decompressor

This block rebuilds a stream of byte-wide symbols, such as compressed machine code, from a stream of fixed-width LZW codes. No translation table travels with the data. The decoder grows its own dictionary by one entry for each code after the first. Because the compressor builds the same table by the same rule, both sides stay in step. Codes 0 to 255 stand for single symbols. Learned entries take the numbers from 256 upward until the code space is used up.

A code enters on a valid/ready handshake. The block follows the chain of prefix codes for that code and pushes one symbol per cycle onto a last-in first-out stack, last symbol first. It then pops the stack to a valid/ready output, one symbol per cycle. The symbols therefore leave in their original order. New codes are refused while a string is being unwound or emitted.

A code can name the very entry that the decoder is about to create. In that case the output is the previous string followed by its own first symbol. The block builds this string by pushing the remembered current character before it walks the previous code.

Top module: `lzw_decoder`

## Requirements
- R1: In the cycle after synchronous reset `rst` is released, `inReady` is 1 and `outValid` is 0. The next accepted code is treated as the first code of a stream.
- R2: The first code after reset must be below 256. It produces exactly one output symbol, equal to the code value, and adds no dictionary entry.
- R3: A later code below 256 produces the single symbol equal to its value. A later code below the next free entry number produces the string stored for that entry.
- R4: A later code equal to or above the next free entry number produces the previous code's string followed by the first symbol of that previous string.
- R5: Each code after the first adds one entry at the next free number, starting at 256 and rising by one each time. The entry holds the previous code's string extended by the first symbol of the current code's string.
- R6: The symbols of a string leave in their original order. While `outReady` stays high, they leave on consecutive cycles with no gap.
- R7: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` does not change.
- R8: `inReady` is low in the cycle after a code is accepted, and stays low while any symbol of that code's string is pending. It is high again in the cycle after the string's last symbol is taken.
- R9: Once all 2^CODE_W code numbers are in use, no further entries are added. Later codes, including the highest code number, still decode against the existing table.
- R10: A reset in the middle of a stream discards all learned entries. After the first code that follows, code 256 is again the next free entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A code is offered on `inCode` |
| inReady | output | 1 | The decoder accepts a code this cycle |
| inCode | input | CODE_W | Fixed-width LZW code |
| outValid | output | 1 | A decoded symbol is on `outData` |
| outReady | input | 1 | The consumer takes the symbol this cycle |
| outData | output | SYM_W | Decoded symbol |

## Verification
The dictionary lives only in the block, so a wrong entry, a wrong entry counter or a stale previous code causes no error at once. It shows up later, as a wrong or wrongly sized string, the first time a later code refers to the damaged entry. This may be many codes afterwards. The bench therefore compares every symbol of long generated streams against the original text, and these streams fill the whole table. A fault in the stack or in the handshake logic shows within the same string, as reversed order, a lost or repeated symbol, or a code accepted too early.

// File: rtl/lzw_pkg.sv
package lzw_pkg;

  // Strobes from the control FSM to the datapath; at most one of
  // load/step/pop is active in a cycle, finish only together with step.
  typedef struct packed {
    logic load;    // latch an accepted code and prepare the walk
    logic step;    // push one symbol of the chain and follow the prefix
    logic finish;  // last step of the walk: update dictionary and history
    logic pop;     // one symbol leaves through the output handshake
  } lzwStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_EMIT = 2'd2
  } lzwState_t;

endpackage

// File: rtl/lzw_ctrl.sv
module lzw_ctrl
  import lzw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       walkLeaf,
  input  logic       stackLast,
  output logic       inReady,
  output logic       outValid,
  output lzwStrobe_t strb
);

  lzwState_t state;
  lzwState_t stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    inReady   = 1'b0;
    outValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.load = 1'b1;
          stateNext = ST_WALK;
        end
      end
      ST_WALK: begin
        strb.step = 1'b1;
        if (walkLeaf) begin
          strb.finish = 1'b1;
          stateNext   = ST_EMIT;
        end
      end
      ST_EMIT: begin
        outValid = 1'b1;
        if (outReady) begin
          strb.pop = 1'b1;
          if (stackLast) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/lzw_datapath.sv
module lzw_datapath
  import lzw_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SYM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lzwStrobe_t        strb,
  input  logic [CODE_W-1:0] inCode,
  output logic              walkLeaf,
  output logic              stackLast,
  output logic [SYM_W-1:0]  outData,
  output logic [CODE_W:0]   nextCode
);

  localparam int ROOTS   = 1 << SYM_W;
  localparam int TOTAL   = 1 << CODE_W;
  localparam int SLOTS   = TOTAL - ROOTS;
  localparam int MAX_LEN = SLOTS + 1;
  localparam int SP_W    = $clog2(MAX_LEN + 1);
  localparam int CNT_W   = CODE_W + 1;

  // Learned entries only; root codes are implied by their value.
  logic [CODE_W-1:0] dictPrefix [SLOTS];
  logic [SYM_W-1:0]  dictSym    [SLOTS];

  logic [SYM_W-1:0]  stackMem   [MAX_LEN];
  logic [SP_W-1:0]   sp;

  logic [CODE_W-1:0] walkPtr;
  logic [CODE_W-1:0] pendCode;
  logic [CODE_W-1:0] prevCode;
  logic [SYM_W-1:0]  curChar;
  logic              firstFlag;

  logic [CODE_W-1:0] slotIdx;
  logic [CODE_W-1:0] nextSlot;
  logic [SP_W-1:0]   topIdx;
  logic [SYM_W-1:0]  pushSym;
  logic              isKnown;
  logic              tableFull;
  logic              unknownCase;
  logic              addOk;

  assign walkLeaf    = (walkPtr >> SYM_W) == '0;
  assign slotIdx     = walkPtr - CODE_W'(ROOTS);
  assign nextSlot    = nextCode[CODE_W-1:0] - CODE_W'(ROOTS);
  assign isKnown     = {1'b0, inCode} < nextCode;
  assign tableFull   = nextCode == CNT_W'(TOTAL);
  assign unknownCase = !firstFlag && !isKnown;
  assign addOk       = !firstFlag && !tableFull;
  assign pushSym     = walkLeaf ? walkPtr[SYM_W-1:0] : dictSym[slotIdx];
  assign topIdx      = sp - SP_W'(1);
  assign outData     = stackMem[topIdx];
  assign stackLast   = sp == SP_W'(1);

  // Dictionary write port: one new entry at the end of each walk.
  always_ff @(posedge clk) begin
    if (!rst && strb.finish && addOk) begin
      dictPrefix[nextSlot] <= prevCode;
      dictSym[nextSlot]    <= walkPtr[SYM_W-1:0];
    end
  end

  // Stack write port: the pending character of an unknown code goes in
  // first, so it ends up as the final symbol of the string.
  always_ff @(posedge clk) begin
    if (!rst) begin
      if (strb.load && unknownCase) stackMem[sp] <= curChar;
      else if (strb.step)           stackMem[sp] <= pushSym;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= '0;
      nextCode  <= CNT_W'(ROOTS);
      firstFlag <= 1'b1;
      walkPtr   <= '0;
      pendCode  <= '0;
      prevCode  <= '0;
      curChar   <= '0;
    end else begin
      if (strb.load) begin
        pendCode <= inCode;
        if (unknownCase) begin
          sp      <= sp + SP_W'(1);
          walkPtr <= prevCode;
        end else begin
          walkPtr <= inCode;
        end
      end
      if (strb.step) begin
        sp <= sp + SP_W'(1);
        if (!walkLeaf) walkPtr <= dictPrefix[slotIdx];
      end
      if (strb.finish) begin
        if (addOk) nextCode <= nextCode + CNT_W'(1);
        prevCode  <= pendCode;
        curChar   <= walkPtr[SYM_W-1:0];
        firstFlag <= 1'b0;
      end
      if (strb.pop) sp <= sp - SP_W'(1);
    end
  end

endmodule

// File: rtl/lzw_decoder.sv
module lzw_decoder
  import lzw_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int SYM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CODE_W-1:0] inCode,
  output logic              outValid,
  input  logic              outReady,
  output logic [SYM_W-1:0]  outData
);

  lzwStrobe_t        strb;
  logic              walkLeaf;
  logic              stackLast;
  logic [CODE_W:0]   nextCode;

  lzw_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .outReady  (outReady),
    .walkLeaf  (walkLeaf),
    .stackLast (stackLast),
    .inReady   (inReady),
    .outValid  (outValid),
    .strb      (strb)
  );

  lzw_datapath #(
    .CODE_W (CODE_W),
    .SYM_W  (SYM_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .inCode    (inCode),
    .walkLeaf  (walkLeaf),
    .stackLast (stackLast),
    .outData   (outData),
    .nextCode  (nextCode)
  );

endmodule

// File: rtl/lzw_checker.sv
module lzw_checker #(
  parameter int CODE_W = 10,
  parameter int SYM_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [SYM_W-1:0]  outData,
  input logic [CODE_W:0]   nextCode
);

  localparam int CNT_W = CODE_W + 1;

  // R1: idle and empty right after reset
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (inReady && !outValid));

  // R8: no code accepted while a symbol is offered
  a_r8_no_accept_while_emit: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  // R8: an accepted code blocks the input for at least the next cycle
  a_r8_stall_after_accept: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);

  // R7: a refused symbol is held unchanged
  a_r7_hold_output: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R5: the entry counter only ever moves up by one
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(nextCode) |-> (nextCode == $past(nextCode) + CNT_W'(1)));

endmodule

bind lzw_decoder lzw_checker #(
  .CODE_W (CODE_W),
  .SYM_W  (SYM_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .nextCode (nextCode)
);

// File: tb/sim_lzw_decoder.sv
module sim_lzw_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 10;
  localparam int SYM_W      = 8;
  localparam int ROOTS      = 1 << SYM_W;
  localparam int TOTAL      = 1 << CODE_W;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic [CODE_W-1:0] inCode = '0;
  logic              outReady = 1'b1;
  logic              inReady;
  logic              outValid;
  logic [SYM_W-1:0]  outData;

  lzw_decoder #(.CODE_W(CODE_W), .SYM_W(SYM_W)) u0 (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inReady  (inReady),
    .inCode   (inCode),
    .outValid (outValid),
    .outReady (outReady),
    .outData  (outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  int    cycle  = 0;
  string curReq = "R1";
  int    expQ[$];          // symbol in bits 7:0, bit 8 marks end of string
  bit    bpMode = 1'b0;

  // bench-side compressor state
  int cPre[TOTAL];
  int cSym[TOTAL];
  int cnt;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycle++;
    if (cycle > WATCHDOG) begin
      check("WD", "watchdog expired", 1, 0);
      finishRun();
    end
  end

  always @(negedge clk) outReady <= bpMode ? (($urandom % 3) != 0) : 1'b1;

  // Output monitor, samples a quarter period before the rising edge.
  bit             prevHeld = 0;
  bit             prevLastXfer = 0;
  bit             prevMidXfer = 0;
  logic [SYM_W-1:0] prevData = '0;

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst) begin
      prevHeld = 0; prevLastXfer = 0; prevMidXfer = 0;
    end else begin
      if (prevHeld)
        check("R7", "held symbol", outValid ? int'(outData) : -1, int'(prevData));
      if (prevLastXfer)
        check("R8", "input ready after last symbol", int'(inReady), 1);
      if (prevMidXfer && outReady)
        check("R6", "no gap inside string", int'(outValid), 1);
      if (outValid && inReady)
        check("R8", "input ready while emitting", 1, 0);
      prevHeld     = outValid && !outReady;
      prevData     = outData;
      prevLastXfer = 0;
      prevMidXfer  = 0;
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(curReq, "unexpected symbol", int'(outData), -1);
        end else begin
          int e;
          e = expQ.pop_front();
          check(curReq, "symbol", int'(outData), e & 255);
          prevLastXfer = e[8];
          prevMidXfer  = !e[8];
        end
      end
    end
  end

  task automatic expectStr(string s);
    for (int i = 0; i < s.len(); i++)
      expQ.push_back(int'(s[i]) | ((i == s.len() - 1) ? 256 : 0));
  endtask

  task automatic sendCode(int c);
    @(negedge clk);
    inValid = 1'b1;
    inCode  = CODE_W'(c);
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (expQ.size() != 0 && t < 50000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    check(curReq, "symbols left undelivered", expQ.size(), 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: state right after reset release
  task automatic testReset();
    curReq = "R1";
    doReset();
    #(CLK_PERIOD/4);
    check("R1", "inReady after reset", int'(inReady), 1);
    check("R1", "outValid after reset", int'(outValid), 0);
  endtask

  // R2: first code is a single symbol
  task automatic testFirst();
    doReset();
    curReq = "R2";
    expectStr("A");
    sendCode(65);
    drain();
  endtask

  // R3 and R5: known codes and entry numbering
  task automatic testKnown();
    doReset();
    curReq = "R3";
    expectStr("A");   sendCode(65);
    expectStr("B");   sendCode(66);   // adds 256 = AB
    expectStr("AB");  sendCode(256);  // adds 257 = BA
    expectStr("C");   sendCode(67);   // adds 258 = ABC
    curReq = "R5";
    expectStr("ABC"); sendCode(258);  // adds 259 = CA
    expectStr("BA");  sendCode(257);
    expectStr("CA");  sendCode(259);
    drain();
  endtask

  // R4: codes that arrive before their own entry exists
  task automatic testUnknown();
    doReset();
    curReq = "R4";
    expectStr("A");    sendCode(65);
    expectStr("AA");   sendCode(256);  // unknown, becomes 256 = AA
    expectStr("AAA");  sendCode(257);  // unknown, becomes 257 = AAA
    expectStr("B");    sendCode(66);   // adds 258 = AAAB
    expectStr("AAAB"); sendCode(258);
    drain();
    doReset();
    expectStr("A");   sendCode(65);
    expectStr("B");   sendCode(66);
    expectStr("AB");  sendCode(256);
    expectStr("ABA"); sendCode(258);   // unknown after 257 = BA
    drain();
  endtask

  // Compress a generated text in the bench, then decode it.
  task automatic runStream(string req, int len, int unsigned seed);
    int txt[$];
    int codes[$];
    int w;
    int st;
    int unsigned s = seed;
    for (int i = 0; i < len; i++) begin
      s = s * 1103515245 + 12345;
      txt.push_back(97 + int'((s >> 16) & 3));
    end
    cnt = ROOTS;
    w   = txt[0];
    st  = 0;
    for (int i = 1; i < len; i++) begin
      int f = -1;
      for (int k = ROOTS; k < cnt; k++)
        if (cPre[k] == w && cSym[k] == txt[i]) begin f = k; break; end
      if (f >= 0) begin
        w = f;
      end else begin
        codes.push_back(w);
        for (int j = st; j < i; j++) expQ.push_back(txt[j] | ((j == i - 1) ? 256 : 0));
        if (cnt < TOTAL) begin cPre[cnt] = w; cSym[cnt] = txt[i]; cnt++; end
        w  = txt[i];
        st = i;
      end
    end
    codes.push_back(w);
    for (int j = st; j < len; j++) expQ.push_back(txt[j] | ((j == len - 1) ? 256 : 0));
    curReq = req;
    foreach (codes[i]) sendCode(codes[i]);
    drain();
  endtask

  // R7: random output stalls during a stream
  task automatic testBackpressure();
    doReset();
    bpMode = 1'b1;
    runStream("R7", 400, 32'h1234);
    bpMode = 1'b0;
  endtask

  // R9: fill the whole table, then use the highest code
  task automatic testFull();
    int q[$];
    int k;
    doReset();
    runStream("R9", 6000, 32'hBEEF);
    check("R9", "stream long enough to fill table", cnt, TOTAL);
    k = TOTAL - 1;
    while (k >= ROOTS) begin q.push_front(cSym[k]); k = cPre[k]; end
    q.push_front(k);
    foreach (q[i]) expQ.push_back(q[i] | ((i == q.size() - 1) ? 256 : 0));
    curReq = "R9";
    sendCode(TOTAL - 1);
    drain();
  endtask

  // R10: reset after a full table forgets every learned entry
  task automatic testRestart();
    doReset();
    curReq = "R10";
    expectStr("A");  sendCode(65);
    expectStr("AA"); sendCode(256);
    drain();
  endtask

  initial begin
    testReset();
    testFirst();
    testKnown();
    testUnknown();
    testBackpressure();
    testFull();
    testRestart();
    finishRun();
  end

endmodule